// File: doc/BRIEF.md
# Multi-channel clock source select, divide and gate bank

This block is a bank of sixteen clock-enable generators driven from one system clock. Four parent sources arrive as single-cycle enable strobes. Each output channel has its own settings. It picks one parent, divides that parent's strobe train by 1, 2, 4 or 8, and can be turned off by a disable bit. The result is one enable strobe per channel, and downstream logic uses it as a qualified clock enable.

Software programs the bank through a small register port with three 32-bit words: one word of disable bits, one of packed source fields and one of packed divide fields. Within a channel the three stages act in series: source select, then the divide counter, then the gate. Rewriting the source word or the divide word restarts every divide counter, so the next output strobe follows the new setting from a clean phase.

Top module: `clkbank_top`

## Requirements
- R1: After reset all three control words read as zero, so every channel is enabled, uses parent 0 and divides by 1. With parent 0 strobing every cycle, every channel then strobes every cycle.
- R2: The words at byte offsets 0x0 (disable bits), 0x4 (source fields) and 0x8 (divide fields) read back their last written value. rd_data holds the value in the cycle after rd_en, and is zero in any cycle after a cycle with rd_en low. The disable word keeps only bits 15:0.
- R3: A read of any other byte address returns zero. A write to any other byte address changes no control word.
- R4: Channel i takes its parent from bits 2i+1:2i of the word at 0x4. The field value p selects par_stb[p].
- R5: Channel i takes its divide code from bits 2i+1:2i of the word at 0x8. Codes 0, 1, 2 and 3 give one output strobe per 1, 2, 4 and 8 strobes of the selected parent.
- R6: Bit i of the word at 0x0 set to 1 stops all output strobes of channel i. Set to 0, it lets them through.
- R7: While a channel is disabled its divide counter keeps counting parent strobes, so re-enabling it does not shift its output phase.
- R8: Any write to 0x4 or 0x8 clears the divide counter of every channel. A parent strobe in that write cycle is discarded, so the first output strobe afterwards comes on exactly the divide-by-th following parent strobe.
- R9: An output strobe is one cycle wide and appears exactly one cycle after the parent strobe that completes the count. No output strobe follows a cycle with no parent strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Byte address of the control word |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| par_stb | input | 4 | Parent clock-enable strobes, one bit per parent |
| ch_stb | output | 16 | Output clock-enable strobes, one bit per channel |

## Verification
The source stage is tried by strobing one parent at a time, each for a different number of cycles. A channel's strobe count then shows which parent it actually follows, so swapped or misplaced fields show up. The divider is tried with a continuous parent train and all four codes present across the channels, which separates an off-by-one limit from a wrong shift. Gate, phase and restart behaviour are tried with short strobe bursts around disable and rewrite events, where a counter that resets on disable or ignores a write gives a different strobe count. A long run with random parent patterns and random register traffic is compared cycle by cycle against a behavioural model.

// File: rtl/clkbank_pkg.sv
package clkbank_pkg;
  // byte offsets of the three control words
  localparam int OFF_GATE = 0;
  localparam int OFF_SEL  = 4;
  localparam int OFF_DIV  = 8;
endpackage

// File: rtl/clkbank_regs.sv
module clkbank_regs
  import clkbank_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter int N_CH   = 16,
  parameter int SEL_W  = 2,
  parameter int DIV_W  = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en,
  input  logic                    rd_en,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [DATA_W-1:0]       wr_data,
  output logic [DATA_W-1:0]       rd_data,
  output logic [N_CH-1:0]         gate_o,
  output logic [N_CH*SEL_W-1:0]   sel_o,
  output logic [N_CH*DIV_W-1:0]   div_o,
  output logic                    clr_o
);
  localparam int SEL_BITS = N_CH * SEL_W;
  localparam int DIV_BITS = N_CH * DIV_W;

  logic hit_gate, hit_sel, hit_div;
  logic [N_CH-1:0]     gate_q;
  logic [SEL_BITS-1:0] sel_q;
  logic [DIV_BITS-1:0] div_q;
  logic [DATA_W-1:0]   rd_q;

  assign hit_gate = (addr == ADDR_W'(OFF_GATE));
  assign hit_sel  = (addr == ADDR_W'(OFF_SEL));
  assign hit_div  = (addr == ADDR_W'(OFF_DIV));

  always_ff @(posedge clk) begin
    if (rst) begin
      gate_q <= '0;
      sel_q  <= '0;
      div_q  <= '0;
    end else if (wr_en) begin
      if (hit_gate) gate_q <= wr_data[N_CH-1:0];
      if (hit_sel)  sel_q  <= wr_data[SEL_BITS-1:0];
      if (hit_div)  div_q  <= wr_data[DIV_BITS-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !rd_en) begin
      rd_q <= '0;
    end else begin
      unique case (1'b1)
        hit_gate: rd_q <= DATA_W'(gate_q);
        hit_sel:  rd_q <= DATA_W'(sel_q);
        hit_div:  rd_q <= DATA_W'(div_q);
        default:  rd_q <= '0;
      endcase
    end
  end

  assign rd_data = rd_q;
  assign gate_o  = gate_q;
  assign sel_o   = sel_q;
  assign div_o   = div_q;
  // a rewrite of either rate field restarts every counter
  assign clr_o   = wr_en && (hit_sel || hit_div);
endmodule

// File: rtl/clkbank_chan.sv
module clkbank_chan #(
  parameter int N_PAR = 4,
  parameter int SEL_W = 2,
  parameter int DIV_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             gate,
  input  logic [SEL_W-1:0] sel,
  input  logic [DIV_W-1:0] div,
  input  logic [N_PAR-1:0] par_stb,
  output logic             stb_o
);
  // largest ratio is 2**(2**DIV_W - 1); the counter spans it
  localparam int CNT_W = (2 ** DIV_W) - 1;

  logic             pick;
  logic [CNT_W:0]   ratio;
  logic [CNT_W:0]   lim_w;
  logic [CNT_W-1:0] lim;
  logic [CNT_W-1:0] cnt_q;
  logic             out_q;
  logic             wrap;

  assign pick  = par_stb[sel];
  assign ratio = (CNT_W + 1)'(1) << div;
  assign lim_w = ratio - (CNT_W + 1)'(1);
  assign lim   = lim_w[CNT_W-1:0];
  assign wrap  = (cnt_q >= lim);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q <= '0;
      out_q <= 1'b0;
    end else if (pick) begin
      // counting continues while gated so phase survives
      cnt_q <= wrap ? '0 : cnt_q + 1'b1;
      out_q <= wrap && !gate;
    end else begin
      out_q <= 1'b0;
    end
  end

  assign stb_o = out_q;
endmodule

// File: rtl/clkbank_top.sv
module clkbank_top #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter int N_CH   = 16,
  parameter int N_PAR  = 4,
  parameter int DIV_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic [N_PAR-1:0]  par_stb,
  output logic [N_CH-1:0]   ch_stb
);
  localparam int SEL_W = (N_PAR > 1) ? $clog2(N_PAR) : 1;

  logic [N_CH-1:0]       gate_q;
  logic [N_CH*SEL_W-1:0] sel_q;
  logic [N_CH*DIV_W-1:0] div_q;
  logic                  clr;

  clkbank_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_CH(N_CH),
    .SEL_W(SEL_W), .DIV_W(DIV_W)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wr_data(wr_data), .rd_data(rd_data),
    .gate_o(gate_q), .sel_o(sel_q), .div_o(div_q), .clr_o(clr)
  );

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    clkbank_chan #(
      .N_PAR(N_PAR), .SEL_W(SEL_W), .DIV_W(DIV_W)
    ) u_ch (
      .clk(clk), .rst(rst), .clr(clr),
      .gate(gate_q[g]),
      .sel(sel_q[g*SEL_W +: SEL_W]),
      .div(div_q[g*DIV_W +: DIV_W]),
      .par_stb(par_stb),
      .stb_o(ch_stb[g])
    );
  end
endmodule

// File: rtl/clkbank_chk.sv
module clkbank_chk #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter int N_CH   = 16,
  parameter int N_PAR  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] rd_data,
  input logic [N_PAR-1:0]  par_stb,
  input logic [N_CH-1:0]   ch_stb,
  input logic [N_CH-1:0]   gate
);
  logic odd_addr;
  assign odd_addr = (addr != ADDR_W'(0)) && (addr != ADDR_W'(4)) && (addr != ADDR_W'(8));

  p_rd_idle_zero_r2: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> (rd_data == '0));

  p_bad_addr_zero_r3: assert property (@(posedge clk) disable iff (rst)
    (rd_en && odd_addr) |=> (rd_data == '0));

  p_gate_blocks_r6: assert property (@(posedge clk) disable iff (rst)
    ((ch_stb & $past(gate)) == '0));

  p_write_restart_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (addr == ADDR_W'(4) || addr == ADDR_W'(8))) |=> (ch_stb == '0));

  p_no_parent_no_out_r9: assert property (@(posedge clk) disable iff (rst)
    (par_stb == '0) |=> (ch_stb == '0));
endmodule

bind clkbank_top clkbank_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_CH(N_CH), .N_PAR(N_PAR)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .rd_data(rd_data), .par_stb(par_stb), .ch_stb(ch_stb), .gate(gate_q)
);

// File: tb/clkbank_top_tb.sv
`timescale 1ns/1ps
module clkbank_top_tb;
  localparam int NC = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wr_data = '0;
  logic [3:0]  par = '0;
  logic [31:0] rd_data;
  logic [15:0] ch_stb;

  always #2.5 clk = ~clk;

  clkbank_top u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .par_stb(par), .ch_stb(ch_stb)
  );

  int n_cmp = 0, n_bad = 0;
  int acc[NC];
  bit done = 0;

  // behavioural reference
  logic [31:0] m_gate, m_sel, m_div, m_rd;
  logic [15:0] m_out;
  int m_cnt[NC];

  always @(posedge clk) begin
    if (rst) begin
      m_gate <= '0; m_sel <= '0; m_div <= '0; m_rd <= '0; m_out <= '0;
      for (int i = 0; i < NC; i++) m_cnt[i] <= 0;
    end else begin
      for (int i = 0; i < NC; i++) begin
        int s, d;
        s = (m_sel >> (2*i)) & 3;
        d = 1 << ((m_div >> (2*i)) & 3);
        if (wr_en && (addr == 4 || addr == 8)) begin
          m_cnt[i] <= 0; m_out[i] <= 1'b0;
        end else if (par[s]) begin
          if (m_cnt[i] + 1 == d) begin
            m_cnt[i] <= 0; m_out[i] <= ~m_gate[i];
          end else begin
            m_cnt[i] <= m_cnt[i] + 1; m_out[i] <= 1'b0;
          end
        end else begin
          m_out[i] <= 1'b0;
        end
      end
      if (wr_en) begin
        if (addr == 0) m_gate <= {16'h0, wr_data[15:0]};
        if (addr == 4) m_sel <= wr_data;
        if (addr == 8) m_div <= wr_data;
      end
      if (!rd_en) m_rd <= '0;
      else if (addr == 0) m_rd <= m_gate;
      else if (addr == 4) m_rd <= m_sel;
      else if (addr == 8) m_rd <= m_div;
      else m_rd <= '0;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    if (!rst) begin
      chk(ch_stb === m_out, "R9 ch_stb vs model", ch_stb, m_out);
      chk(rd_data === m_rd, "R2 rd_data vs model", rd_data, m_rd);
    end
    for (int i = 0; i < NC; i++) acc[i] += int'(ch_stb[i]);
  endtask

  task automatic clr_acc();
    for (int i = 0; i < NC; i++) acc[i] = 0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wr_data = d;
    step();
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    rd_en = 1'b1; addr = a;
    step();
    rd_en = 1'b0;
    v = rd_data;
  endtask

  task automatic run(input int n, input logic [3:0] p);
    par = p;
    for (int k = 0; k < n; k++) step();
    par = '0;
  endtask

  initial begin
    #1ms;
    if (!done) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    clr_acc();
    repeat (3) step();
    rst = 1'b0;
    step();

    // R1: reset values and default behaviour
    rd(4'h0, v); chk(v == 0, "R1 gate word after reset", v, 0);
    rd(4'h4, v); chk(v == 0, "R1 select word after reset", v, 0);
    rd(4'h8, v); chk(v == 0, "R1 divide word after reset", v, 0);
    clr_acc(); run(10, 4'h1);
    for (int i = 0; i < NC; i++) chk(acc[i] == 10, "R1 default strobes", acc[i], 10);

    // R2: readback
    wr(4'h0, 32'h1234_5A5A); rd(4'h0, v); chk(v == 32'h5A5A, "R2 gate readback", v, 32'h5A5A);
    wr(4'h4, 32'hDEAD_BEEF); rd(4'h4, v); chk(v == 32'hDEAD_BEEF, "R2 select readback", v, 32'hDEAD_BEEF);
    wr(4'h8, 32'h0F0F_3C3C); rd(4'h8, v); chk(v == 32'h0F0F_3C3C, "R2 divide readback", v, 32'h0F0F_3C3C);
    step(); chk(rd_data == 0, "R2 idle read zero", rd_data, 0);

    // R3: other offsets
    wr(4'hC, 32'hFFFF_FFFF);
    rd(4'hC, v); chk(v == 0, "R3 read 0xC", v, 0);
    rd(4'h2, v); chk(v == 0, "R3 read 0x2", v, 0);
    rd(4'h0, v); chk(v == 32'h5A5A, "R3 gate untouched", v, 32'h5A5A);
    wr(4'h0, 0); wr(4'h4, 0); wr(4'h8, 0);

    // R4: source field selects parent; parent p strobed (p+1)*3 times
    wr(4'h4, 32'hE4E4_E4E4);
    clr_acc();
    for (int p = 0; p < 4; p++) run((p+1)*3, 4'(1 << p));
    for (int i = 0; i < NC; i++)
      chk(acc[i] == ((i%4)+1)*3, "R4 parent choice", acc[i], ((i%4)+1)*3);

    // R5: divide code i%4
    wr(4'h4, 0); wr(4'h8, 32'hE4E4_E4E4);
    clr_acc(); run(64, 4'h1);
    for (int i = 0; i < NC; i++)
      chk(acc[i] == (64 >> (i%4)), "R5 divide ratio", acc[i], 64 >> (i%4));

    // R6: disable bits
    wr(4'h8, 0); wr(4'h0, 32'hAAAA);
    clr_acc(); run(12, 4'h1);
    for (int i = 0; i < NC; i++)
      chk(acc[i] == ((i%2) ? 0 : 12), "R6 gate", acc[i], (i%2) ? 0 : 12);

    // R7: phase kept while disabled
    wr(4'h8, 32'hFFFF_FFFF); wr(4'h0, 32'hFFFF);
    clr_acc(); run(5, 4'h1);
    for (int i = 0; i < NC; i++) chk(acc[i] == 0, "R7 silent while off", acc[i], 0);
    wr(4'h0, 0); run(3, 4'h1);
    for (int i = 0; i < NC; i++) chk(acc[i] == 1, "R7 phase after enable", acc[i], 1);
    run(8, 4'h1);
    for (int i = 0; i < NC; i++) chk(acc[i] == 2, "R7 next period", acc[i], 2);

    // R8: write restarts counters, discarding parent strobe
    run(5, 4'h1);
    par = 4'h1; wr(4'h4, 0); par = 4'h0;
    clr_acc(); run(7, 4'h1);
    for (int i = 0; i < NC; i++) chk(acc[i] == 0, "R8 no early strobe", acc[i], 0);
    run(1, 4'h1);
    for (int i = 0; i < NC; i++) chk(acc[i] == 1, "R8 strobe on 8th", acc[i], 1);

    // R9: latency and width
    wr(4'h8, 0); step();
    par = 4'h1; step(); par = 4'h0;
    chk(ch_stb == 16'hFFFF, "R9 one-cycle latency", ch_stb, 16'hFFFF);
    step();
    chk(ch_stb == 16'h0, "R9 single-cycle width", ch_stb, 0);

    // mixed random traffic against the model
    for (int k = 0; k < 3000; k++) begin
      par = 4'($urandom);
      if (($urandom % 16) == 0) begin
        wr_en = 1'b1; addr = 4'(($urandom % 4) * 4); wr_data = $urandom;
      end
      rd_en = (($urandom % 8) == 0);
      if (rd_en && !wr_en) addr = 4'($urandom);
      step();
      wr_en = 1'b0; rd_en = 1'b0;
    end
    par = '0;
    step();

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule